// File: doc/BRIEF.md
# LIN Controller Mode Manager

This block keeps the operating mode of a LIN controller: Initialization, Normal or Sleep. Software chooses the mode by writing two request bits in a control register. An Initialization request always wins. With no Initialization request, the Sleep request picks between Sleep and Normal. A wake-up event sets a sticky flag. When auto-wake-up is enabled, that flag makes the hardware drop the Sleep request, so the controller returns to Normal without software stepping in.

The block also holds a configuration bit that picks what a full one-message receive buffer does with the next message: overwrite the stored one, or discard the new one. That bit can only change while the block is in Initialization mode. An overrun flag records every arrival at a full buffer. Reading the buffer empties it. Bit timing and frame decoding sit elsewhere; the block only sees a message strobe and its payload.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the block is in Initialization mode with the init request at 1, the sleep request, auto-wake enable and lock bit at 0, and the buffer-full flag, overrun flag and wake flag at 0.
- R2: While the init request bit is 1, mode_o is Initialization (code 0) one cycle later, whatever the sleep request.
- R3: With init request 0, mode_o is Normal (code 1) one cycle later if the sleep request is 0, and Sleep (code 2) if it is 1.
- R4: A pulse on wake_i sets the wake flag (status bit 0). Writing 1 to that bit clears it.
- R5: When auto-wake enable (control bit 2) and the wake flag are both 1, the hardware clears the sleep request on the next edge, even over a software write in the same cycle.
- R6: The lock bit (control bit 3) takes a written value only when mode_o is Initialization. In any other mode a write leaves it unchanged.
- R7: With lock 0, a message arriving while the buffer is full replaces the stored message.
- R8: With lock 1, a message arriving while the buffer is full is dropped and the stored message is kept.
- R9: The overrun flag (status bit 1) is set by any arrival while the buffer is full, under either policy, and is cleared by writing 1 to it.
- R10: A message arriving with the buffer empty is stored and sets buffer-full (status bit 2). A read strobe at address 2 clears buffer-full.
- R11: Register map: address 0 is control (bit 0 init request, bit 1 sleep request, bit 2 auto-wake enable, bit 3 lock); address 1 is status; address 2 returns the stored message. rdata_o follows addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; at address 2 it empties the buffer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| wake_i | input | 1 | Wake-up event pulse |
| msg_valid_i | input | 1 | Message arrival strobe |
| msg_data_i | input | 8 | Message payload |
| mode_o | output | 2 | 0 Initialization, 1 Normal, 2 Sleep |
| buf_full_o | output | 1 | Receive buffer holds an unread message |
| overrun_o | output | 1 | Overrun flag |

## Verification
The following properties are checked on every cycle:
- the mode follows the request bits with the init request taking priority;
- the lock bit holds its value outside Initialization;
- the hardware wake clear takes effect;
- arrivals at a full buffer raise overrun;
- the discard policy keeps the stored payload.

Only the bench scenarios can show the following:
- the register map and the W1C behaviour as seen through rdata_o;
- the overwrite policy delivering the newest payload;
- the full round trip from Sleep back to Normal after a wake pulse;
- that a lock write in Normal mode has no effect when read back.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_INIT   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SLEEP  = 2'd2
  } mode_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_DATA = 2;

  localparam int unsigned CB_INIT  = 0;
  localparam int unsigned CB_SLEEP = 1;
  localparam int unsigned CB_AWAKE = 2;
  localparam int unsigned CB_LOCK  = 3;

  localparam int unsigned SB_WAKE = 0;
  localparam int unsigned SB_OVR  = 1;
  localparam int unsigned SB_FULL = 2;
endpackage

// File: rtl/lin_mode_regs.sv
module lin_mode_regs
  import lin_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              in_init_i,
  input  logic              wake_i,
  output logic              init_o,
  output logic              sleep_o,
  output logic              awake_o,
  output logic              lock_o,
  output logic              wake_flag_o
);
  logic hw_clr;
  assign hw_clr = awake_o & wake_flag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o  <= 1'b1;
      sleep_o <= 1'b0;
      awake_o <= 1'b0;
      lock_o  <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        init_o  <= wdata_i[CB_INIT];
        sleep_o <= wdata_i[CB_SLEEP];
        awake_o <= wdata_i[CB_AWAKE];
        if (in_init_i) lock_o <= wdata_i[CB_LOCK];
      end
      if (hw_clr) sleep_o <= 1'b0;  // wake-up overrides software
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wake_flag_o <= 1'b0;
    else if (wake_i)                      wake_flag_o <= 1'b1;
    else if (wr_stat_i && wdata_i[SB_WAKE]) wake_flag_o <= 1'b0;
  end
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  init_i,
  input  logic  sleep_i,
  output mode_e mode_o
);
  mode_e mode_d;

  always_comb begin
    if (init_i)       mode_d = MODE_INIT;
    else if (sleep_i) mode_d = MODE_SLEEP;
    else              mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_INIT;
    else         mode_o <= mode_d;
  end
endmodule

// File: rtl/lin_rx_buf.sv
module lin_rx_buf #(
  parameter int unsigned MSG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic [MSG_W-1:0] msg_data_i,
  input  logic             lock_i,
  input  logic             rd_clr_i,
  input  logic             ovr_clr_i,
  output logic [MSG_W-1:0] data_o,
  output logic             full_o,
  output logic             ovr_o
);
  logic full_eff;
  assign full_eff = full_o & ~rd_clr_i;  // a read in the same cycle frees the slot

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      full_o <= full_eff;
      if (ovr_clr_i) ovr_o <= 1'b0;
      if (msg_valid_i) begin
        full_o <= 1'b1;
        if (full_eff) begin
          ovr_o <= 1'b1;
          if (!lock_i) data_o <= msg_data_i;
        end else begin
          data_o <= msg_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MSG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wake_i,
  input  logic              msg_valid_i,
  input  logic [MSG_W-1:0]  msg_data_i,
  output logic [1:0]        mode_o,
  output logic              buf_full_o,
  output logic              overrun_o
);
  localparam int unsigned CP_W = (MSG_W < DATA_W) ? MSG_W : DATA_W;

  logic init_q, sleep_q, awake_q, lock_q, wake_flag_q;
  logic sel_ctrl, sel_stat, sel_data;
  logic [MSG_W-1:0] msg_q;
  mode_e mode_q;

  assign sel_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_stat = (addr_i == ADDR_W'(ADDR_STAT));
  assign sel_data = (addr_i == ADDR_W'(ADDR_DATA));

  lin_mode_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_en_i & sel_ctrl),
    .wr_stat_i  (wr_en_i & sel_stat),
    .wdata_i    (wdata_i),
    .in_init_i  (mode_q == MODE_INIT),
    .wake_i     (wake_i),
    .init_o     (init_q),
    .sleep_o    (sleep_q),
    .awake_o    (awake_q),
    .lock_o     (lock_q),
    .wake_flag_o(wake_flag_q)
  );

  lin_mode_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_q),
    .sleep_i(sleep_q),
    .mode_o (mode_q)
  );

  lin_rx_buf #(.MSG_W(MSG_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_valid_i(msg_valid_i),
    .msg_data_i (msg_data_i),
    .lock_i     (lock_q),
    .rd_clr_i   (rd_en_i & sel_data),
    .ovr_clr_i  (wr_en_i & sel_stat & wdata_i[SB_OVR]),
    .data_o     (msg_q),
    .full_o     (buf_full_o),
    .ovr_o      (overrun_o)
  );

  assign mode_o = mode_q;

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[CB_INIT]  = init_q;
      rdata_o[CB_SLEEP] = sleep_q;
      rdata_o[CB_AWAKE] = awake_q;
      rdata_o[CB_LOCK]  = lock_q;
    end else if (sel_stat) begin
      rdata_o[SB_WAKE] = wake_flag_q;
      rdata_o[SB_OVR]  = overrun_o;
      rdata_o[SB_FULL] = buf_full_o;
    end else if (sel_data) begin
      rdata_o[CP_W-1:0] = msg_q[CP_W-1:0];
    end
  end
endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned MSG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_o,
  input logic              init_q,
  input logic              sleep_q,
  input logic              awake_q,
  input logic              wake_flag_q,
  input logic              lock_q,
  input logic              buf_full_o,
  input logic              overrun_o,
  input logic              msg_valid_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [MSG_W-1:0]  msg_q
);
  logic rd_clr;
  assign rd_clr = rd_en_i && (addr_i == ADDR_W'(2));

  AST_INIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> (mode_o == 2'd0)); // R2

  AST_RUN_OR_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> (mode_o == ($past(sleep_q) ? 2'd2 : 2'd1))); // R3

  AST_HW_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_q && wake_flag_q) |=> !sleep_q); // R5

  AST_LOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |=> $stable(lock_q)); // R6

  AST_KEEP_ON_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && buf_full_o && msg_valid_i && !rd_clr) |=> $stable(msg_q)); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full_o && msg_valid_i && !rd_clr) |=> overrun_o); // R9

  AST_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |=> buf_full_o); // R10
endmodule

bind lin_mode_ctrl lin_mode_chk #(.ADDR_W(ADDR_W), .MSG_W(MSG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_o     (mode_o),
  .init_q     (init_q),
  .sleep_q    (sleep_q),
  .awake_q    (awake_q),
  .wake_flag_q(wake_flag_q),
  .lock_q     (lock_q),
  .buf_full_o (buf_full_o),
  .overrun_o  (overrun_o),
  .msg_valid_i(msg_valid_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .msg_q      (msg_q)
);

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wake = 1'b0, msg_valid = 1'b0;
  logic [7:0] msg_data = '0;
  logic [1:0] mode;
  logic       full, ovr;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  lin_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .wake_i(wake), .msg_valid_i(msg_valid),
    .msg_data_i(msg_data), .mode_o(mode), .buf_full_o(full), .overrun_o(ovr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_pop(output logic [7:0] d);
    @(negedge clk); addr = 2'd2; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); msg_valid = 1'b1; msg_data = d;
    @(negedge clk); msg_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 mode", {6'd0, mode}, 8'd0);
    rd(2'd0, v); check("R1 ctrl", v, 8'h01);
    rd(2'd1, v); check("R1 status", v, 8'h00);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    wr(2'd0, 8'h03); @(negedge clk);
    check("R2 init over sleep", {6'd0, mode}, 8'd0);
    wr(2'd0, 8'h02); @(negedge clk);
    check("R3 sleep", {6'd0, mode}, 8'd2);
    wr(2'd0, 8'h00); @(negedge clk);
    check("R3 normal", {6'd0, mode}, 8'd1);
    rd(2'd0, v); check("R11 ctrl readback", v, 8'h00);
  endtask

  task automatic t_lock;
    logic [7:0] v;
    wr(2'd0, 8'h08); @(negedge clk);  // in Normal: lock write ignored
    rd(2'd0, v); check("R6 lock blocked", v, 8'h00);
    wr(2'd0, 8'h01); @(negedge clk);
    check("R2 back to init", {6'd0, mode}, 8'd0);
    wr(2'd0, 8'h09); wr(2'd0, 8'h08); @(negedge clk);
    rd(2'd0, v); check("R6 lock taken in init", v, 8'h08);
    check("R3 normal locked", {6'd0, mode}, 8'd1);
  endtask

  task automatic t_discard;
    logic [7:0] v;
    send(8'hA1);
    rd(2'd1, v); check("R10 full set", v, 8'h04);
    send(8'hB2);
    rd(2'd1, v); check("R9 overrun under lock", v, 8'h06);
    rd_pop(v); check("R8 stored kept", v, 8'hA1);
    check("R10 read empties", {7'd0, full}, 8'd0);
    wr(2'd1, 8'h02);
    check("R9 overrun cleared", {7'd0, ovr}, 8'd0);
  endtask

  task automatic t_overwrite;
    logic [7:0] v;
    wr(2'd0, 8'h01); @(negedge clk);
    wr(2'd0, 8'h01); wr(2'd0, 8'h00); @(negedge clk);  // lock back to 0
    rd(2'd0, v); check("R6 unlock in init", v, 8'h00);
    send(8'h11); send(8'h22); send(8'h33);
    check("R9 overrun overwrite", {7'd0, ovr}, 8'd1);
    rd_pop(v); check("R7 newest kept", v, 8'h33);
    wr(2'd1, 8'h02);
  endtask

  task automatic t_wake;
    logic [7:0] v;
    wr(2'd0, 8'h02); @(negedge clk);
    check("R3 asleep", {6'd0, mode}, 8'd2);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    rd(2'd1, v); check("R4 wake flag no awake", v, 8'h01);
    check("R5 stays asleep without enable", {6'd0, mode}, 8'd2);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R4 wake flag cleared", v, 8'h00);
    wr(2'd0, 8'h06); @(negedge clk);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(2'd0, v); check("R5 sleep cleared by hw", v, 8'h04);
    check("R5 back to normal", {6'd0, mode}, 8'd1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_lock();
    t_discard();
    t_overwrite();
    t_wake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule